// File: doc/BRIEF.md
# Flash Bank Status Read Generator

This block forms the word returned on a read cycle of a multi-bank NOR flash while a program or erase runs in one of its banks. It takes the read strobe, the read address and the word fetched from the array. From the operation side it takes a busy flag, the operation kind, the bank under modification, the word being programmed, an erase-suspend flag, the set of blocks chosen for erase, and pulses that report a failure or a status clear. For each read it decides whether the caller sees array contents or a status word made of polling, toggle, error and second-toggle bits.

Reads to any bank other than the busy one pass array contents through unchanged, so code can run from one bank while another is modified. The two toggle bits advance once for each new read cycle, which is a rising edge of the strobe. Holding the strobe high does not advance them. A failure latches an error state that keeps the status word in place after the operation ends, until a clear arrives.

Top module: `flash_status_read`

## Requirements
- R1: After synchronous reset `rd_valid` is 0, `rd_data` is 0 and both toggle bits start at 0, so the first status read after reset shows bit 6 = 0 and bit 2 = 0.
- R2: A read returns `array_data` unchanged when no operation is busy and no error is latched, or when the addressed bank differs from `op_bank`.
- R3: In the busy bank during a program (`op_kind` = 0, no suspend in effect), status bit 7 is the inverse of bit 7 of `prog_word`.
- R4: In the busy bank during an erase that is not suspended (`op_kind` = 1), status bit 7 is 0.
- R5: Bit 6 of the status word inverts on every new read cycle that returns a normal (not suspended) status word, starting from its current value.
- R6: Only a rising edge of `rd_en` starts a read cycle. `rd_valid` pulses for exactly one cycle, one clock after that edge. `rd_data` holds its value while the strobe stays high.
- R7: Bit 2 inverts only on reads that address a block whose bit in `erase_mask` is set, while an erase is active, suspended, or failed. On other status reads it keeps its value. The block index is address bits [ADDR_W-1 : ADDR_W-BLK_W].
- R8: During erase suspend (`susp` = 1 with an erase and no error), a read of a block marked in `erase_mask` returns bit 7 = 1, bit 6 unchanged from the previous status read, bit 5 = 0, and an inverting bit 2. Unmarked blocks in the same bank return array data.
- R9: `fail_pulse` latches an error. Status words then show bit 5 = 1 and continue in the failing bank even after `op_busy` falls. `clear_cmd` removes the error, and `clear_cmd` wins over a simultaneous `fail_pulse`.
- R10: When an operation ends without error, reads of its bank return array data, and the toggle bits keep their last values until the next status read.
- R11: The bank follows the top three address bits: value 0 is bank 0, values 1 to 3 are bank 1, values 4 to 6 are bank 2, and value 7 is bank 3. This gives banks of one, three, three and one eighths of the space.
- R12: A status word has every bit other than 7, 6, 5 and 2 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, level; a rising edge starts a read cycle |
| rd_addr | input | ADDR_W | Word address of the read |
| array_data | input | DATA_W | Word fetched from the array at `rd_addr` |
| op_busy | input | 1 | A program or erase is running |
| op_kind | input | 1 | 0 = program, 1 = erase |
| op_bank | input | 2 | Bank being modified |
| prog_word | input | DATA_W | Word being programmed |
| susp | input | 1 | Erase is suspended |
| erase_mask | input | 2**BLK_W | One bit per block chosen for erase |
| fail_pulse | input | 1 | One-cycle report that the operation failed |
| clear_cmd | input | 1 | One-cycle status clear |
| rd_data | output | DATA_W | Word returned for the last read cycle |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |

## Verification
The assertions check on every cycle that a valid pulse never lasts two cycles and that the returned word changes only together with it. They also check that idle reads echo the array word, that the polling bit matches the program or erase rule, and that the error state persists until it is cleared. The alternation of bit 6, the choice of blocks for bit 2, the frozen bit 6 under suspend, and the bank boundaries depend on the history of read cycles. Only the bench's scenarios show these, by comparing against a model that tracks both toggle bits.

// File: rtl/flash_stat_pkg.sv
// Shared definitions for the flash status read generator.
// Assumes the status bit positions are fixed by the host polling software.
package flash_stat_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_t;

    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;
    localparam int ERR_BIT  = 5;
    localparam int ALT_BIT  = 2;

    // Map the top three address bits onto the 1/3/3/1 eighths bank split.
    function automatic logic [1:0] bank_of_top(input logic [2:0] top);
        logic [1:0] b;
        if (top == 3'd0)      b = 2'd0;
        else if (top < 3'd4)  b = 2'd1;
        else if (top < 3'd7)  b = 2'd2;
        else                  b = 2'd3;
        return b;
    endfunction

endpackage

// File: rtl/fsr_addr_decode.sv
// Address decode: tells whether the read hits the busy bank and whether the
// addressed block is one chosen for erase.
// Assumes BLK_W >= 3 so the block index covers the bank select bits.
module fsr_addr_decode #(
    parameter int ADDR_W = 22,
    parameter int BLK_W  = 6
) (
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [1:0]          op_bank,
    input  logic [2**BLK_W-1:0] erase_mask,
    output logic                bank_hit,
    output logic                blk_sel
);
    import flash_stat_pkg::*;

    localparam int TOP_LSB = ADDR_W - 3;
    localparam int BLK_LSB = ADDR_W - BLK_W;

    logic [2:0]       top_bits;
    logic [BLK_W-1:0] blk_idx;

    // Slice the bank and block fields and look them up.
    always_comb begin
        top_bits = rd_addr[ADDR_W-1:TOP_LSB];
        blk_idx  = rd_addr[ADDR_W-1:BLK_LSB];
        bank_hit = (bank_of_top(top_bits) == op_bank);
        blk_sel  = erase_mask[blk_idx];
    end

endmodule

// File: rtl/fsr_status_mux.sv
// Chooses array data or a status word and says which toggle bits a read
// cycle would advance. Purely combinational.
// Assumes DATA_W >= 8 and that susp is only meaningful for an erase.
module fsr_status_mux #(
    parameter int DATA_W = 16
) (
    input  logic              op_busy,
    input  logic              err_q,
    input  logic              op_kind,
    input  logic              susp,
    input  logic              bank_hit,
    input  logic              blk_sel,
    input  logic              prog_msb,
    input  logic [DATA_W-1:0] array_data,
    input  logic              tgl6,
    input  logic              tgl2,
    output logic [DATA_W-1:0] word,
    output logic              flip6,
    output logic              flip2
);
    import flash_stat_pkg::*;

    op_kind_t kind;
    logic     engaged;
    logic     in_susp;

    // Classify the read and assemble the returned word.
    always_comb begin
        kind    = op_kind_t'(op_kind);
        engaged = (op_busy | err_q) & bank_hit;
        in_susp = susp & (kind == OP_ERASE) & ~err_q;
        word    = array_data;
        flip6   = 1'b0;
        flip2   = 1'b0;
        if (engaged && in_susp) begin
            if (blk_sel) begin
                word           = '0;
                word[POLL_BIT] = 1'b1;
                word[TGL_BIT]  = tgl6;
                word[ALT_BIT]  = tgl2;
                flip2          = 1'b1;
            end
        end else if (engaged) begin
            word           = '0;
            word[POLL_BIT] = (kind == OP_PROG) ? ~prog_msb : 1'b0;
            word[TGL_BIT]  = tgl6;
            word[ERR_BIT]  = err_q;
            word[ALT_BIT]  = tgl2;
            flip6          = 1'b1;
            flip2          = (kind == OP_ERASE) & blk_sel;
        end
    end

endmodule

// File: rtl/fsr_toggle_unit.sv
// Detects the start of a read cycle (strobe rising edge) and keeps the two
// toggle bits, advancing each only on a cycle start that requests it.
// Assumes rd_en is synchronous to clk.
module fsr_toggle_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic flip6,
    input  logic flip2,
    output logic rd_start,
    output logic tgl6,
    output logic tgl2
);
    logic rd_en_q;

    // Edge detect on the read strobe.
    assign rd_start = rd_en & ~rd_en_q;

    // Remember the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_en_q <= 1'b0;
        else        rd_en_q <= rd_en;
    end

    // Advance the toggle bits once per qualifying read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl6 <= 1'b0;
            tgl2 <= 1'b0;
        end else if (rd_start) begin
            if (flip6) tgl6 <= ~tgl6;
            if (flip2) tgl2 <= ~tgl2;
        end
    end

endmodule

// File: rtl/flash_status_read.sv
// Top of the flash status read generator: latches the error state, decodes
// the address, forms the returned word and registers it per read cycle.
// Assumes op_bank, op_kind and erase_mask stay steady for an operation.
module flash_status_read #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]   array_data,
    input  logic                op_busy,
    input  logic                op_kind,
    input  logic [1:0]          op_bank,
    input  logic [DATA_W-1:0]   prog_word,
    input  logic                susp,
    input  logic [2**BLK_W-1:0] erase_mask,
    input  logic                fail_pulse,
    input  logic                clear_cmd,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid
);
    import flash_stat_pkg::*;

    logic              err_q;
    logic              bank_hit;
    logic              blk_sel;
    logic              rd_start;
    logic              tgl6;
    logic              tgl2;
    logic              flip6;
    logic              flip2;
    logic [DATA_W-1:0] word;

    // Sticky error state; a clear wins over a simultaneous failure.
    always_ff @(posedge clk) begin
        if (!rst_n)          err_q <= 1'b0;
        else if (clear_cmd)  err_q <= 1'b0;
        else if (fail_pulse) err_q <= 1'b1;
    end

    fsr_addr_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dec (
        .rd_addr    (rd_addr),
        .op_bank    (op_bank),
        .erase_mask (erase_mask),
        .bank_hit   (bank_hit),
        .blk_sel    (blk_sel)
    );

    fsr_status_mux #(.DATA_W(DATA_W)) u_mux (
        .op_busy    (op_busy),
        .err_q      (err_q),
        .op_kind    (op_kind),
        .susp       (susp),
        .bank_hit   (bank_hit),
        .blk_sel    (blk_sel),
        .prog_msb   (prog_word[POLL_BIT]),
        .array_data (array_data),
        .tgl6       (tgl6),
        .tgl2       (tgl2),
        .word       (word),
        .flip6      (flip6),
        .flip2      (flip2)
    );

    fsr_toggle_unit u_tgl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .flip6    (flip6),
        .flip2    (flip2),
        .rd_start (rd_start),
        .tgl6     (tgl6),
        .tgl2     (tgl2)
    );

    // Capture the returned word once per read cycle and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_start;
            if (rd_start) rd_data <= word;
        end
    end

endmodule

// File: rtl/flash_status_read_chk.sv
// Assertion checker for flash_status_read, attached by bind below.
// Assumes the same parameter defaults as the top module.
module flash_status_read_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              op_busy,
    input logic              op_kind,
    input logic              susp,
    input logic              bank_hit,
    input logic              err_q,
    input logic              clear_cmd,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] prog_word,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid
);
    // R6: a valid pulse never lasts two cycles.
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6: the returned word only changes together with a valid pulse.
    assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

    // R2: with nothing busy and no error, the array word is echoed.
    assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !$past(op_busy) && !$past(err_q) |-> rd_data == $past(array_data));

    // R3: program polling bit is the inverse of the programmed bit.
    assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && $past(op_busy) && !$past(op_kind) && $past(bank_hit)
        |-> rd_data[7] == !$past(prog_word[7]));

    // R4: erase polling bit is 0 when not suspended.
    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && $past(op_busy) && $past(op_kind) && !$past(susp) && $past(bank_hit)
        |-> rd_data[7] == 1'b0);

    // R9: a latched error stays until a clear arrives.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !clear_cmd |=> err_q);

    // R9: a clear always removes the error.
    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cmd |=> !err_q);

endmodule

bind flash_status_read flash_status_read_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .op_busy    (op_busy),
    .op_kind    (op_kind),
    .susp       (susp),
    .bank_hit   (bank_hit),
    .err_q      (err_q),
    .clear_cmd  (clear_cmd),
    .array_data (array_data),
    .prog_word  (prog_word),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
);

// File: tb/sim_flash_status_read.sv
// Self-checking bench: directed corner cases then seeded random reads,
// compared with a bench-side model of the status word and toggle bits.
module sim_flash_status_read;
    localparam int ADDR_W = 22;
    localparam int DATA_W = 16;
    localparam int BLK_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] array_data = '0;
    logic              op_busy = 1'b0;
    logic              op_kind = 1'b0;
    logic [1:0]        op_bank = 2'd0;
    logic [DATA_W-1:0] prog_word = '0;
    logic              susp = 1'b0;
    logic [63:0]       erase_mask = '0;
    logic              fail_pulse = 1'b0;
    logic              clear_cmd = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    int checks = 0;
    int errors = 0;
    logic m_err = 1'b0;
    logic t6 = 1'b0;
    logic t2 = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    flash_status_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .array_data(array_data), .op_busy(op_busy), .op_kind(op_kind),
        .op_bank(op_bank), .prog_word(prog_word), .susp(susp),
        .erase_mask(erase_mask), .fail_pulse(fail_pulse), .clear_cmd(clear_cmd),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] bank_of(input logic [ADDR_W-1:0] a);
        logic [2:0] t = a[ADDR_W-1:ADDR_W-3];
        if (t == 0) return 2'd0;
        if (t < 4)  return 2'd1;
        if (t < 7)  return 2'd2;
        return 2'd3;
    endfunction

    // Expected word and toggle requests for a read, from the requirements.
    task automatic calc(input logic [ADDR_W-1:0] a, input logic [15:0] arr,
                        output logic [15:0] w, output logic f6, output logic f2);
        logic hit, sel, sus;
        hit = (op_busy || m_err) && (bank_of(a) == op_bank);
        sel = erase_mask[a[ADDR_W-1:ADDR_W-BLK_W]];
        sus = susp && op_kind && !m_err;
        w = arr; f6 = 0; f2 = 0;
        if (hit && sus) begin
            if (sel) begin
                w = '0; w[7] = 1'b1; w[6] = t6; w[2] = t2; f2 = 1'b1;
            end
        end else if (hit) begin
            w = '0;
            w[7] = op_kind ? 1'b0 : ~prog_word[7];
            w[6] = t6; w[5] = m_err; w[2] = t2;
            f6 = 1'b1; f2 = op_kind && sel;
        end
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string tag, input logic hold);
        logic [15:0] w;
        logic f6, f2;
        @(negedge clk);
        rd_addr = a;
        array_data = 16'($urandom);
        rd_en = 1'b1;
        calc(a, array_data, w, f6, f2);
        @(negedge clk);
        chk(rd_valid == 1'b1, {tag, " R6 valid"}, {15'd0, rd_valid}, 16'd1);
        chk(rd_data == w, tag, rd_data, w);
        t6 ^= f6; t2 ^= f2;
        if (hold) begin
            array_data = 16'($urandom);
            @(negedge clk);
            chk(rd_valid == 1'b0, "R6 held strobe valid", {15'd0, rd_valid}, 16'd0);
            chk(rd_data == w, "R6 held strobe data", rd_data, w);
        end
        rd_en = 1'b0;
    endtask

    function automatic logic [ADDR_W-1:0] addr_at(input int blk);
        return {6'(blk), 16'($urandom)};
    endfunction

    task automatic pulse_fail();
        @(negedge clk); fail_pulse = 1'b1;
        @(negedge clk); fail_pulse = 1'b0; m_err = 1'b1;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear_cmd = 1'b1;
        @(negedge clk); clear_cmd = 1'b0; m_err = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b0, "R1 reset valid", {15'd0, rd_valid}, 16'd0);
        chk(rd_data == '0, "R1 reset data", rd_data, 16'd0);
        rst_n = 1'b1;

        // R2: idle reads echo array data.
        for (int i = 0; i < 4; i++) do_read(addr_at(i * 17), "R2 idle", 1'b0);

        // R3, R11, R1, R5: program in bank 1; blocks 8..31 hit it.
        op_bank = 2'd1; op_kind = 1'b0; op_busy = 1'b1; prog_word = 16'h0080;
        do_read(addr_at(8), "R1 R3 first status", 1'b0);
        do_read(addr_at(31), "R5 R11 second status", 1'b0);
        do_read(addr_at(7), "R11 bank0 array", 1'b0);
        do_read(addr_at(32), "R11 bank2 array", 1'b0);
        do_read(addr_at(63), "R11 bank3 array", 1'b0);
        prog_word = 16'h1234;
        do_read(addr_at(20), "R3 R12 program poll", 1'b1);
        do_read(addr_at(20), "R5 after hold", 1'b0);

        // R4, R7: erase in bank 2, blocks 33 and 40 selected.
        @(negedge clk);
        op_bank = 2'd2; op_kind = 1'b1; erase_mask = '0;
        erase_mask[33] = 1'b1; erase_mask[40] = 1'b1;
        do_read(addr_at(33), "R4 R7 erase block", 1'b0);
        do_read(addr_at(34), "R7 non-erase block", 1'b0);
        do_read(addr_at(40), "R7 erase block again", 1'b0);

        // R8: suspend.
        @(negedge clk); susp = 1'b1;
        do_read(addr_at(40), "R8 suspended block", 1'b0);
        do_read(addr_at(35), "R8 unselected block", 1'b0);
        do_read(addr_at(33), "R8 suspended block again", 1'b0);
        @(negedge clk); susp = 1'b0;

        // R10: completion without error.
        @(negedge clk); op_busy = 1'b0;
        do_read(addr_at(33), "R10 done array", 1'b0);
        @(negedge clk); op_busy = 1'b1;
        do_read(addr_at(33), "R10 toggles kept", 1'b0);

        // R9: failure, drop busy, then clear; clear wins over fail.
        pulse_fail();
        @(negedge clk); op_busy = 1'b0;
        do_read(addr_at(36), "R9 error persists", 1'b0);
        do_read(addr_at(0), "R9 other bank", 1'b0);
        @(negedge clk); clear_cmd = 1'b1; fail_pulse = 1'b1;
        @(negedge clk); clear_cmd = 1'b0; fail_pulse = 1'b0; m_err = 1'b0;
        do_read(addr_at(36), "R9 cleared", 1'b0);

        // Random mix against the model.
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                op_busy = 1'($urandom);
                op_kind = 1'($urandom);
                susp = ($urandom_range(0, 3) == 0);
                prog_word = 16'($urandom);
                erase_mask = {$urandom, $urandom};
                if (!m_err) op_bank = 2'($urandom);
            end
            if ($urandom_range(0, 19) == 0) pulse_fail();
            else if (m_err && $urandom_range(0, 9) == 0) pulse_clear();
            do_read(addr_at($urandom_range(0, 63)), "R2 R5 R7 R8 random", 1'($urandom_range(0, 4) == 0));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule